// File: doc/BRIEF.md
# Single-channel block-move DMA engine

The engine copies a block of words between an I/O device and consecutive memory locations, so that the CPU does not have to move each word itself. Software sets it up through a small port window. It writes a start word address to one port and a word count to another. It then writes the control port with the go bit set and a direction bit. From that point the engine is master of the memory bus and of the device handshake, while the CPU carries on with other work. Every word is fetched from the source into an internal buffer, then stored to the destination. After each store the count drops by one and the address rises by one. When the count reaches zero the engine raises its interrupt.

The controller runs as one state machine with five states. IDLE waits for a go command, and the go edge leads to CHECK. CHECK moves to DONE when no words remain and to READ otherwise. READ holds its source strobe until the source signals ready, then captures the word and moves to WRITE. WRITE holds its destination strobe until the destination signals ready, then updates the counters and returns to CHECK. DONE sets the interrupt and returns to IDLE. The interrupt stays set until software writes the acknowledge port. Writes to the address, count and control ports are accepted only in IDLE.

Top module: `dma_engine`

## Requirements
- R1: After reset the interrupt is low and none of mem_req, dev_rd or dev_wr is asserted.
- R2: A write with cfg_sel=0 loads the start word address, and cfg_sel=1 loads the word count. A write with cfg_sel=2 and bit 0 set starts a transfer, and bit 1 of that same write selects the direction: 1 moves data from device to memory, 0 moves data from memory to device.
- R3: In the device-to-memory direction, each word is read with dev_rd and then written to memory with mem_req=1 and mem_we=1, carrying the value the device returned. The memory bus is never read.
- R4: In the memory-to-device direction, each word is read from memory with mem_req=1 and mem_we=0, then written to the device with dev_wr, carrying the value memory returned. Memory is never written.
- R5: A transfer of n words starting at address X moves exactly n words, at addresses X, X+1, ..., X+n-1, in ascending order.
- R6: Each read or write phase keeps its strobe, address and write data unchanged until the matching ready input is seen high at a clock edge.
- R7: The interrupt rises after the store of the last word completes. It stays high until a write with cfg_sel=3, and it is low from the edge that takes that write.
- R8: A go command with a word count of zero raises the interrupt no later than the second clock edge after the go write. It makes no memory or device access.
- R9: Writes to cfg_sel 0, 1 or 2 made while a transfer is running change neither the ongoing transfer's addresses nor its word count, and they do not start a new transfer.
- R10: A write with cfg_sel=2 and bit 0 clear starts nothing: no access is made and the interrupt stays low.
- R11: At most one of mem_req, dev_rd and dev_wr is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | CPU port write strobe |
| cfg_sel | input | 2 | Port select: 0 address, 1 count, 2 control, 3 interrupt acknowledge |
| cfg_wdata | input | REG_W | CPU write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the access at this edge |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wdata | output | DATA_W | Data to the device |
| dev_rdata | input | DATA_W | Data from the device, valid with dev_ready |
| dev_ready | input | 1 | Device completes the access at this edge |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The hardest case to reach is a port write that arrives while the engine is partway through a word and is stalled waiting for a ready. In that state the write must have no effect, and that is visible only through the later addresses and the number of words moved. The bench's memory and device models add a programmable number of wait cycles before each ready. This keeps the engine in READ and WRITE long enough for all three configuration ports to be written in the middle of a block. The bench then compares the full logged address and data sequences with those of the original programming.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_CHECK,
        ST_DONE
    } dma_state_t;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam logic [1:0] SEL_ACK   = 2'd3;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_DIR_BIT = 1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16,
    parameter int REG_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [REG_W-1:0]   cfg_wdata,
    input  logic               idle,
    input  logic               step,
    input  logic               done_pulse,
    output logic [ADDR_W-1:0]  cur_addr,
    output logic               count_zero,
    output logic               dir_in,
    output logic               go_pulse,
    output logic               irq
);

    logic [COUNT_W-1:0] words_left;
    logic               wr_addr;
    logic               wr_count;
    logic               wr_ack;
    logic               unused_wdata;

    assign wr_addr    = cfg_we && idle && (cfg_sel == SEL_ADDR);
    assign wr_count   = cfg_we && idle && (cfg_sel == SEL_COUNT);
    assign go_pulse   = cfg_we && idle && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_GO_BIT];
    assign wr_ack     = cfg_we && (cfg_sel == SEL_ACK);
    assign count_zero = (words_left == '0);
    assign unused_wdata = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            words_left <= '0;
            dir_in     <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (wr_addr) begin
                cur_addr <= cfg_wdata[ADDR_W-1:0];
            end else if (step) begin
                cur_addr <= cur_addr + ADDR_W'(1);
            end
            if (wr_count) begin
                words_left <= cfg_wdata[COUNT_W-1:0];
            end else if (step) begin
                words_left <= words_left - COUNT_W'(1);
            end
            if (go_pulse) begin
                dir_in <= cfg_wdata[CTRL_DIR_BIT];
            end
            if (done_pulse) begin
                irq <= 1'b1;
            end else if (wr_ack) begin
                irq <= 1'b0;
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (words_left != '0)); // R5

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cur_addr == $past(cur_addr) + ADDR_W'(1))); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !step) |=> ($stable(cur_addr) && $stable(words_left))); // R9

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> irq); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ack) |=> irq); // R7

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_pulse,
    input  logic              dir_in,
    input  logic              count_zero,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ready,
    output logic              idle,
    output logic              step,
    output logic              done_pulse,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata
);

    dma_state_t        state;
    dma_state_t        state_nxt;
    logic [DATA_W-1:0] word_buf;
    logic              src_ack;
    logic              dst_ack;

    assign src_ack = dir_in ? dev_ready : mem_ready;
    assign dst_ack = dir_in ? mem_ready : dev_ready;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (go_pulse) state_nxt = ST_CHECK;
            ST_CHECK: state_nxt = count_zero ? ST_DONE : ST_READ;
            ST_READ:  if (src_ack) state_nxt = ST_WRITE;
            ST_WRITE: if (dst_ack) state_nxt = ST_CHECK;
            ST_DONE:  state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            word_buf <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_READ && src_ack) begin
                word_buf <= dir_in ? dev_rdata : mem_rdata;
            end
        end
    end

    always_comb begin
        idle       = (state == ST_IDLE);
        step       = 1'b0;
        done_pulse = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_addr;
        mem_wdata  = word_buf;
        dev_rd     = 1'b0;
        dev_wr     = 1'b0;
        dev_wdata  = word_buf;
        unique case (state)
            ST_READ: begin
                if (dir_in) dev_rd  = 1'b1;
                else        mem_req = 1'b1;
            end
            ST_WRITE: begin
                step = dst_ack;
                if (dir_in) begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                end else begin
                    dev_wr = 1'b1;
                end
            end
            ST_DONE: done_pulse = 1'b1;
            default: ;
        endcase
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, dev_rd, dev_wr})); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !(mem_req || dev_rd || dev_wr)); // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata))); // R6

    AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_rd || dev_wr) && !dev_ready) |=> ($stable(dev_rd) && $stable(dev_wr)
                                                && $stable(dev_wdata))); // R6

endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
    parameter int ADDR_W  = 16,
    parameter int COUNT_W = 16,
    parameter int DATA_W  = 32,
    parameter int REG_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    input  logic              dev_ready,
    output logic              irq
);

    logic              idle;
    logic              step;
    logic              done_pulse;
    logic [ADDR_W-1:0] cur_addr;
    logic              count_zero;
    logic              dir_in;
    logic              go_pulse;

    dma_regs #(
        .ADDR_W  (ADDR_W),
        .COUNT_W (COUNT_W),
        .REG_W   (REG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .idle       (idle),
        .step       (step),
        .done_pulse (done_pulse),
        .cur_addr   (cur_addr),
        .count_zero (count_zero),
        .dir_in     (dir_in),
        .go_pulse   (go_pulse),
        .irq        (irq)
    );

    dma_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_pulse   (go_pulse),
        .dir_in     (dir_in),
        .count_zero (count_zero),
        .cur_addr   (cur_addr),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .dev_rdata  (dev_rdata),
        .dev_ready  (dev_ready),
        .idle       (idle),
        .step       (step),
        .done_pulse (done_pulse),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .dev_rd     (dev_rd),
        .dev_wr     (dev_wr),
        .dev_wdata  (dev_wdata)
    );

endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int RW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [RW-1:0] cfg_wdata = '0;
    logic          mem_req, mem_we, dev_rd, dev_wr, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, dev_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] dev_rdata = '0;
    logic          mem_ready = 1'b0;
    logic          dev_ready = 1'b0;

    always #2 clk = ~clk;

    dma_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_ready(dev_ready),
        .irq(irq)
    );

    // Bus and device models: decide ready at the falling edge and commit there.
    logic [DW-1:0] mem [256];
    logic [AW-1:0] rd_addr_log [64];
    logic [AW-1:0] wr_addr_log [64];
    logic [DW-1:0] dev_log [64];
    int mem_rd_n = 0, mem_wr_n = 0, dev_rd_n = 0, dev_wr_n = 0;
    int hold_err = 0, strobe_err = 0;
    int lat = 0;
    int mem_wait = 0, dev_wait = 0;
    logic          p_mreq = 0, p_mack = 0, p_dreq = 0, p_dack = 0, p_we = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_mwd = '0, p_dwd = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i;
        end
        if ((32'(mem_req) + 32'(dev_rd) + 32'(dev_wr)) > 1) strobe_err++;
        if (mem_req && p_mreq && !p_mack &&
            (mem_addr != p_addr || mem_we != p_we || (mem_we && mem_wdata != p_mwd)))
            hold_err++;
        if ((dev_rd || dev_wr) && p_dreq && !p_dack && dev_wr && dev_wdata != p_dwd)
            hold_err++;
        mem_ready = 1'b0;
        dev_ready = 1'b0;
        if (mem_req) begin
            if (mem_wait >= lat) begin
                mem_ready = 1'b1;
                mem_wait = 0;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_addr_log[mem_wr_n[5:0]] = mem_addr;
                    mem_wr_n++;
                end else begin
                    mem_rdata = mem[mem_addr[7:0]];
                    rd_addr_log[mem_rd_n[5:0]] = mem_addr;
                    mem_rd_n++;
                end
            end else mem_wait++;
        end
        if (dev_rd || dev_wr) begin
            if (dev_wait >= lat) begin
                dev_ready = 1'b1;
                dev_wait = 0;
                if (dev_rd) begin
                    dev_rdata = 32'hA500_0000 + dev_rd_n;
                    dev_rd_n++;
                end else begin
                    dev_log[dev_wr_n[5:0]] = dev_wdata;
                    dev_wr_n++;
                end
            end else dev_wait++;
        end
        p_mreq = mem_req; p_mack = mem_ready; p_addr = mem_addr;
        p_we = mem_we; p_mwd = mem_wdata;
        p_dreq = dev_rd || dev_wr; p_dack = dev_ready; p_dwd = dev_wdata;
    end

    int n_chk = 0, n_fail = 0;
    bit timed_out = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [RW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq(output bit seen);
        seen = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (irq) seen = 1;
        end
    endtask

    task automatic start_xfer(input int addr, input int n, input bit to_mem);
        cfg_write(2'd0, RW'(addr));   // R2 address port
        cfg_write(2'd1, RW'(n));      // R2 count port
        cfg_write(2'd2, {14'd0, to_mem, 1'b1}); // R2 go with direction bit 1
    endtask

    task automatic t_reset;
        chk(irq == 1'b0, "R1 irq low after reset", 32'(irq), 0);
        chk(!(mem_req || dev_rd || dev_wr), "R1 no strobe after reset",
            {29'd0, mem_req, dev_rd, dev_wr}, 0);
    endtask

    task automatic t_dev_to_mem;
        int mw0 = mem_wr_n, mr0 = mem_rd_n, dr0 = dev_rd_n;
        bit seen;
        lat = 2;
        start_xfer(16'h40, 5, 1'b1);
        wait_irq(seen);
        chk(seen, "R7 irq after device-to-memory block", 32'(seen), 1);
        chk(mem_wr_n - mw0 == 5, "R5 five memory writes", mem_wr_n - mw0, 5);
        chk(dev_rd_n - dr0 == 5, "R3 five device reads", dev_rd_n - dr0, 5);
        chk(mem_rd_n == mr0, "R3 no memory read", mem_rd_n - mr0, 0);
        for (int k = 0; k < 5; k++) begin
            chk(wr_addr_log[(mw0 + k) % 64] == AW'(16'h40 + k), "R5 write address order",
                32'(wr_addr_log[(mw0 + k) % 64]), 32'h40 + k);
            chk(mem[8'h40 + k] == 32'hA500_0000 + dr0 + k, "R3 stored device word",
                mem[8'h40 + k], 32'hA500_0000 + dr0 + k);
        end
        chk(hold_err == 0, "R6 phases stable while waiting", hold_err, 0);
        repeat (6) @(negedge clk);
        chk(irq == 1'b1, "R7 irq held until acknowledge", 32'(irq), 1);
        cfg_write(2'd3, '0);
        chk(irq == 1'b0, "R7 irq cleared by acknowledge", 32'(irq), 0);
    endtask

    task automatic t_mem_to_dev;
        int mw0 = mem_wr_n, mr0 = mem_rd_n, dw0 = dev_wr_n;
        bit seen;
        lat = 0;
        start_xfer(16'h80, 4, 1'b0);
        wait_irq(seen);
        chk(seen, "R7 irq after memory-to-device block", 32'(seen), 1);
        chk(dev_wr_n - dw0 == 4, "R4 four device writes", dev_wr_n - dw0, 4);
        chk(mem_wr_n == mw0, "R4 no memory write", mem_wr_n - mw0, 0);
        for (int k = 0; k < 4; k++) begin
            chk(rd_addr_log[(mr0 + k) % 64] == AW'(16'h80 + k), "R5 read address order",
                32'(rd_addr_log[(mr0 + k) % 64]), 32'h80 + k);
            chk(dev_log[(dw0 + k) % 64] == 32'hC0DE_0080 + k, "R4 device got memory word",
                dev_log[(dw0 + k) % 64], 32'hC0DE_0080 + k);
        end
        cfg_write(2'd3, '0);
    endtask

    task automatic t_zero_count;
        int acc0 = mem_rd_n + mem_wr_n + dev_rd_n + dev_wr_n;
        bit seen = 0;
        cfg_write(2'd0, 16'h20);
        cfg_write(2'd1, 16'd0);
        cfg_write(2'd2, 16'h0003);
        for (int i = 0; i < 3 && !seen; i++) begin
            @(negedge clk);
            if (irq) seen = 1;
        end
        chk(seen, "R8 zero count raises irq at once", 32'(seen), 1);
        chk(mem_rd_n + mem_wr_n + dev_rd_n + dev_wr_n == acc0, "R8 zero count no access",
            mem_rd_n + mem_wr_n + dev_rd_n + dev_wr_n - acc0, 0);
        cfg_write(2'd3, '0);
    endtask

    task automatic t_ignore_busy;
        int mw0 = mem_wr_n, mr0 = mem_rd_n, dw0 = dev_wr_n;
        bit seen;
        lat = 3;
        start_xfer(16'h10, 3, 1'b0);
        repeat (4) @(negedge clk);
        cfg_write(2'd0, 16'h99);
        cfg_write(2'd1, 16'd9);
        cfg_write(2'd2, 16'h0003);
        wait_irq(seen);
        chk(seen, "R9 transfer completes", 32'(seen), 1);
        chk(dev_wr_n - dw0 == 3, "R9 count unchanged by busy write", dev_wr_n - dw0, 3);
        chk(mem_wr_n == mw0, "R9 busy go did not start input block", mem_wr_n - mw0, 0);
        for (int k = 0; k < 3; k++)
            chk(rd_addr_log[(mr0 + k) % 64] == AW'(16'h10 + k), "R9 address unchanged",
                32'(rd_addr_log[(mr0 + k) % 64]), 32'h10 + k);
        repeat (10) @(negedge clk);
        chk(mem_rd_n - mr0 == 3, "R9 no restart after completion", mem_rd_n - mr0, 3);
        cfg_write(2'd3, '0);
    endtask

    task automatic t_no_go;
        int acc0 = mem_rd_n + mem_wr_n + dev_rd_n + dev_wr_n;
        lat = 0;
        cfg_write(2'd0, 16'h30);
        cfg_write(2'd1, 16'd2);
        cfg_write(2'd2, 16'h0002);
        repeat (10) @(negedge clk);
        chk(mem_rd_n + mem_wr_n + dev_rd_n + dev_wr_n == acc0, "R10 no access without go",
            mem_rd_n + mem_wr_n + dev_rd_n + dev_wr_n - acc0, 0);
        chk(irq == 1'b0, "R10 irq low without go", 32'(irq), 0);
        chk(strobe_err == 0, "R11 single strobe throughout", strobe_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                @(negedge clk);
                t_reset();
                t_dev_to_mem();
                t_mem_to_dev();
                t_zero_count();
                t_ignore_busy();
                t_no_go();
            end
            begin
                repeat (100000) @(negedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule